// File: doc/BRIEF.md
# Pruned Six-Stage CIC Decimator

This block lowers the sample rate of a 16-bit signed stream by a factor of 40. It is a cascade of six integrators running on every input clock, followed by six first-order differencers that run once per 40 input clocks. The input needs no handshake: one sample is taken on every rising clock edge. Once every 40 clocks a 16-bit signed result appears together with a one-cycle valid strobe.

All stages share one 48-bit weight frame, whose most significant bit is the same for every stage. Each stage register holds only the upper part of that frame that it needs, and the low bits below each stage's own weight are dropped as the data moves down the chain. Integrators wrap in two's complement and the differencers undo the wrap. The last reduction to 16 bits rounds to nearest. A plain truncation there would leave a small negative bias, which shows up as an output that flips between 0 and -1.

The DC gain is 40^6, which is not a power of two. The output is read as the top 16 bits of the 48-bit frame, so a DC level comes out at about 0.954 of the input. Downstream filtering corrects this gain if needed.

Top module: `cic_pruned_dec`

## Requirements
- R1: The reset `rst_n` is synchronous and active low. It clears every integrator, every differencer delay, the decimation counter and the output. After reset `dout` is 0 and `dout_valid` is 0. While the input stays all-zero, `dout` remains exactly 0.
- R2: `dout_valid` is high for exactly one clock in every 40. The first pulse is visible after the 40th rising edge that follows the release of reset. Each pulse follows the internal decimation strobe by one clock.
- R3: `dout` changes only on clocks where `dout_valid` is high. Between pulses it holds its last value.
- R4: The input is sign-extended into a 48-bit frame, with the input LSB at frame bit 0. The integrator widths are 46, 41, 36, 32, 28 and 24 bits. Each integrator adds the top bits of the previous stage (the first integrator adds the top bits of the extended input) to itself on every clock. The addition wraps modulo 2^width.
- R5: The differencer widths are 24, 21, 21, 20, 19 and 18 bits. The first one takes all 24 bits of the last integrator, and each later one takes the top bits of the stage before it. Each computes its input minus its input from the previous decimation strobe, with wraparound at its own width. Its delay register updates only on the decimation strobe.
- R6: Let v be the 18-bit last differencer value. Then `dout` = floor((v + 2) / 4): round to nearest, with ties going toward plus infinity. A result above 32767 is clamped to 32767.
- R7: For a constant input x held for at least 480 clocks, `dout` lies within 8 of floor(x * 40^6 / 2^32).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 16 | Signed input sample, taken every clock |
| dout | output | 16 | Signed decimated result, rounded to nearest |
| dout_valid | output | 1 | One-cycle strobe marking a new `dout` |

## Verification
The bound checker watches the output timing on every cycle. It checks the exact 40-clock spacing of valid pulses and their single-cycle width, and that each pulse follows the decimation strobe. It also checks that `dout` holds still between pulses. The arithmetic can only be shown by the bench's scenarios: the per-stage bit dropping, the wraparound, the differencing at the decimated rate and the rounding. The bench compares every cycle against a bit-true model built from the stated widths, using impulses, a sweep of DC levels across the full input range, Nyquist-rate patterns, random input and a reset in mid-stream. The DC sweep also compares against the ideal gain.

// File: rtl/cic_pkg.sv
package cic_pkg;
    // number of integrator stages, equal to the number of differencer stages
    localparam int NSTG = 6;
    // per-stage register widths; every stage keeps the MSB of the 48-bit frame
    localparam int INT_W_DEF [NSTG] = '{46, 41, 36, 32, 28, 24};
    localparam int CMB_W_DEF [NSTG] = '{24, 21, 21, 20, 19, 18};
endpackage

// File: rtl/cic_integrator.sv
// One wrapping accumulator holding the top ACC_W bits of the frame.
module cic_integrator #(
    parameter int FRAME_W = 48,
    parameter int ACC_W   = 46
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] in_frame,
    output logic [FRAME_W-1:0] out_frame
);
    localparam int SH = FRAME_W - ACC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } integ_st_t;

    integ_st_t        st_d, st_q;
    logic [ACC_W-1:0] addend;

    always_comb begin
        addend     = ACC_W'(in_frame >> SH);
        st_d       = st_q;
        st_d.acc   = st_q.acc + addend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_frame = FRAME_W'(st_q.acc) << SH;
endmodule

// File: rtl/cic_comb.sv
// First-order differencer at the decimated rate, CMB_W bits wide.
module cic_comb #(
    parameter int FRAME_W = 48,
    parameter int CMB_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [FRAME_W-1:0] in_frame,
    output logic [FRAME_W-1:0] out_frame
);
    localparam int SH = FRAME_W - CMB_W;

    typedef struct packed {
        logic [CMB_W-1:0] dly;
    } comb_st_t;

    comb_st_t         st_d, st_q;
    logic [CMB_W-1:0] cur;
    logic [CMB_W-1:0] diff;

    always_comb begin
        cur      = CMB_W'(in_frame >> SH);
        diff     = cur - st_q.dly;
        st_d     = st_q;
        if (en) st_d.dly = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_frame = FRAME_W'(diff) << SH;
endmodule

// File: rtl/cic_decim_ctr.sv
// Modulo-RATE counter giving a one-clock strobe in its last state.
module cic_decim_ctr #(
    parameter int RATE = 40
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb
);
    localparam int CNT_W = (RATE > 2) ? $clog2(RATE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb = (st_q.cnt == LAST);
endmodule

// File: rtl/cic_pruned_dec.sv
// Six-stage decimating integrator/differencer chain with per-stage widths.
module cic_pruned_dec #(
    parameter int IN_W   = 16,
    parameter int OUT_W  = 16,
    parameter int RATE   = 40,
    parameter int FULL_W = 48,
    parameter int INT_W [cic_pkg::NSTG] = cic_pkg::INT_W_DEF,
    parameter int CMB_W [cic_pkg::NSTG] = cic_pkg::CMB_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout,
    output logic             dout_valid
);
    localparam int NS     = cic_pkg::NSTG;
    localparam int LAST_W = CMB_W[NS-1];
    localparam int DROP   = LAST_W - OUT_W;
    localparam logic [LAST_W:0] HALF = (LAST_W+1)'(1) << (DROP - 1);

    typedef struct packed {
        logic [OUT_W-1:0] dout;
        logic             vld;
    } out_st_t;

    logic [FULL_W-1:0] int_frame [NS+1];
    logic [FULL_W-1:0] cmb_frame [NS+1];
    logic              dec_stb;

    logic [LAST_W-1:0] tail;
    logic [LAST_W:0]   biased;
    logic [OUT_W:0]    rnd;
    logic [OUT_W-1:0]  res;
    out_st_t           out_d, out_q;

    // input sign-extended with its LSB at frame bit 0
    assign int_frame[0] = {{(FULL_W-IN_W){din[IN_W-1]}}, din};

    cic_decim_ctr #(.RATE(RATE)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (dec_stb)
    );

    for (genvar g = 0; g < NS; g++) begin : g_int
        cic_integrator #(.FRAME_W(FULL_W), .ACC_W(INT_W[g])) u_int (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_frame  (int_frame[g]),
            .out_frame (int_frame[g+1])
        );
    end

    assign cmb_frame[0] = int_frame[NS];

    for (genvar g = 0; g < NS; g++) begin : g_cmb
        cic_comb #(.FRAME_W(FULL_W), .CMB_W(CMB_W[g])) u_cmb (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (dec_stb),
            .in_frame  (cmb_frame[g]),
            .out_frame (cmb_frame[g+1])
        );
    end

    // round to nearest (ties upward), then clamp into OUT_W bits
    always_comb begin
        tail   = LAST_W'(cmb_frame[NS] >> (FULL_W - LAST_W));
        biased = {tail[LAST_W-1], tail} + HALF;
        rnd    = (OUT_W+1)'(biased >> DROP);
        case (rnd[OUT_W:OUT_W-1])
            2'b01:   res = {1'b0, {(OUT_W-1){1'b1}}};
            2'b10:   res = {1'b1, {(OUT_W-1){1'b0}}};
            default: res = rnd[OUT_W-1:0];
        endcase
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = dec_stb;
        if (dec_stb) out_d.dout = res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dout       = out_q.dout;
    assign dout_valid = out_q.vld;
endmodule

// File: rtl/cic_pruned_dec_chk.sv
// Output-timing checker, bound into the decimator.
module cic_pruned_dec_chk #(
    parameter int RATE  = 40,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dout_valid,
    input logic [OUT_W-1:0] dout,
    input logic             dec_stb
);
    localparam int GW = $clog2(RATE + 2) + 1;

    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic          live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
            if (dout_valid) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                gap_q  <= gap_q + 1'b1;
            end
        end
    end

    a_r2_gap_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && dout_valid) |-> (gap_q == GW'(RATE - 1)));

    a_r2_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GW'(RATE));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

    a_r2_stb_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stb |=> dout_valid);

    a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_stb |=> !dout_valid);

    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !dout_valid) |-> $stable(dout));
endmodule

bind cic_pruned_dec cic_pruned_dec_chk #(.RATE(RATE), .OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dout_valid (dout_valid),
    .dout       (dout),
    .dec_stb    (dec_stb)
);

// File: tb/test_cic_pruned_dec.sv
module test_cic_pruned_dec;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 48;
    localparam int WI [6] = '{46, 41, 36, 32, 28, 24};
    localparam int WC [6] = '{24, 21, 21, 20, 19, 18};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_valid;

    int     n_run = 0;
    int     n_fail = 0;
    int     cyc_i = 0;
    bit     mon_on = 0;
    bit     zero_phase = 0;
    logic [15:0] prev_dout = '0;

    // bit-true reference state
    longint m_acc [6];
    longint m_dly [6];
    int     m_cnt = 0;
    longint m_dout = 0;
    bit     m_valid = 0;

    cic_pruned_dec i_cic_pruned_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint wrapw(longint v, int w);
        longint one = 1;
        longint m;
        m = v & ((one << w) - 1);
        if (((m >> (w - 1)) & 1) != 0) m = m - (one << w);
        return m;
    endfunction

    function automatic longint realign(longint v, int w_from, int w_to);
        longint r;
        if (w_from >= w_to) r = v >>> (w_from - w_to);
        else                r = v <<< (w_to - w_from);
        return wrapw(r, w_to);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) begin
                m_acc[k] = 0;
                m_dly[k] = 0;
            end
            m_cnt = 0; m_dout = 0; m_valid = 0;
        end else begin
            longint na [6];
            longint x, y, r;
            na[0] = wrapw(m_acc[0] + realign(longint'($signed(din)), FW, WI[0]), WI[0]);
            for (int k = 1; k < 6; k++)
                na[k] = wrapw(m_acc[k] + realign(m_acc[k-1], WI[k-1], WI[k]), WI[k]);
            if (m_cnt == 39) begin
                y = 0;
                x = realign(m_acc[5], WI[5], WC[0]);
                for (int k = 0; k < 6; k++) begin
                    if (k > 0) x = realign(y, WC[k-1], WC[k]);
                    y = wrapw(x - m_dly[k], WC[k]);
                    m_dly[k] = x;
                end
                r = (y + 2) >>> 2;
                if (r > 32767) r = 32767;
                m_dout = r;
                m_valid = 1;
            end else begin
                m_valid = 0;
            end
            for (int k = 0; k < 6; k++) m_acc[k] = na[k];
            m_cnt = (m_cnt == 39) ? 0 : m_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic [15:0] v);
        @(negedge clk);
        cyc_i++;
        if (mon_on) begin
            check(dout_valid === m_valid && dout === m_dout[15:0],
                  "R4 R5 R6 bit-exact output", longint'($signed(dout)), m_dout);
            if (!dout_valid)
                check(dout === prev_dout, "R3 hold between pulses",
                      longint'($signed(dout)), longint'($signed(prev_dout)));
            if (dout_valid)
                check(cyc_i % 40 == 0, "R2 pulse spacing", cyc_i % 40, 0);
            if (cyc_i == 40)
                check(dout_valid === 1'b1, "R2 first pulse", longint'(dout_valid), 1);
            if (zero_phase && dout_valid)
                check(dout === 16'd0, "R1 zero input gives zero",
                      longint'($signed(dout)), 0);
            prev_dout = dout;
        end
        din = v;
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        din = '0;
        repeat (n) @(negedge clk);
        check(dout === 16'd0, "R1 reset dout", longint'($signed(dout)), 0);
        check(dout_valid === 1'b0, "R1 reset valid", longint'(dout_valid), 0);
        rst_n = 1'b1;
        cyc_i = 0;
        prev_dout = '0;
        mon_on = 1;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        do_reset(3);

        // R1: all-zero input stays exactly zero
        zero_phase = 1;
        repeat (400) tick(16'd0);
        zero_phase = 0;

        // positive and negative full-scale impulses (R4 R5 R6)
        tick(16'h7fff);
        repeat (600) tick(16'd0);
        tick(16'h8000);
        repeat (600) tick(16'd0);

        // R7: DC sweep across the full range
        for (int l = 0; l < 16; l++) begin
            longint xv, ideal, act;
            xv = -32768 + l * 4369;
            repeat (480) tick(16'(xv));
            ideal = (xv * 64'sd4096000000) >>> 32;
            act = longint'($signed(dout));
            check((act - ideal <= 8) && (ideal - act <= 8), "R7 DC gain", act, ideal);
        end

        // Nyquist-rate alternation and slow square wave
        for (int i = 0; i < 800; i++) tick((i % 2 == 0) ? 16'h7fff : 16'h8000);
        for (int i = 0; i < 800; i++) tick(((i / 40) % 2 == 0) ? 16'h7fff : 16'h8000);

        // small ramp exercising the rounding ties
        for (int i = 0; i < 1200; i++) tick(16'(i - 600));

        // random stream
        for (int i = 0; i < 4000; i++) tick(16'($urandom));

        // R1: reset mid-stream, then zero input
        do_reset(2);
        zero_phase = 1;
        repeat (300) tick(16'd0);
        zero_phase = 0;

        // random after reset
        for (int i = 0; i < 2000; i++) tick(16'($urandom));

        summary();
        $finish;
    end
endmodule